// File: doc/BRIEF.md
# Fail-Safe Clock Monitor with Start-Up Switchover

This block compares an external primary oscillator against a slow internal sample clock. When the primary stops toggling, the block moves the system clock select over to the internal oscillator. It enters a fail-safe state and raises a failure flag that stays set. With a crystal-type oscillator, the select is held on the internal oscillator while the primary starts up. It stays there, with monitoring suppressed, until a start-up timer has counted a set number of primary-clock cycles.

All control logic runs from the internal oscillator clock `clk_int`. The primary and sample clocks are treated as slow inputs: each passes through a synchronizer, and its edges are detected in the `clk_int` domain. A test latch is set on each rising edge of the sample clock and cleared by a synchronized rising edge of the primary. If the latch is still set when the sample clock falls, a failure is declared. The block only produces a registered select bit. Glitch-free muxing of the clocks themselves happens elsewhere.

The oscillator mode codes are 0 (low-power crystal), 1 (standard crystal), 2 (high-speed crystal), 3 (external clock) and 4 (RC). Codes 5 to 7 behave like the non-crystal modes. The select bit `sys_sel` is 1 for the internal oscillator and 0 for the primary.

Top module: `fscm_switchover`

## Requirements
- R1: After reset release, or after a wake, in a crystal mode (codes 0, 1, 2), the block is in start-up: `startup_done`=0, `sys_sel`=1 and `fs_active`=0.
- R2: In start-up, once OST_CYCLES rising edges of the primary clock have been seen, `startup_done` becomes 1 and `sys_sel` follows the software select bit (0 after reset).
- R3: In modes 3 to 7 there is no start-up wait. `startup_done`=1 a few cycles after reset release, and monitoring is active at once.
- R4: During start-up, failure detection is suppressed. With the primary stopped and the sample clock toggling, `fs_active` and `fail_flag` stay 0.
- R5: While monitoring, if a full sample-clock high phase passes with no primary rising edge, `fs_active` and `fail_flag` both rise on the same cycle.
- R6: While the primary keeps toggling (at least one rising edge per sample-clock high phase), no failure is declared.
- R7: While `fs_active`=1, `sys_sel`=1 whatever the software select bit holds.
- R8: A `flag_clr` pulse has no effect while `fs_active`=1. Once fail-safe has been left, a `flag_clr` pulse clears `fail_flag`.
- R9: Fail-safe is left only by reset, by `sleep_enter`, or by a `sel_wr` whose `sel_wr_data` differs from the stored select bit. A write of the same value leaves it set.
- R10: A `freq_wr` pulse loads `freq_data` into `int_freq` in any state, including fail-safe, and does not change `fs_active`.
- R11: `sleep_enter` clears fail-safe and sets `startup_done`=0 and `sys_sel`=1. `wake` then restarts the sequence as after reset, while `fail_flag` keeps its value.
- R12: Outside fail-safe and start-up, a `sel_wr` pulse stores `sel_wr_data`, and `sys_sel` follows the stored bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_int | input | 1 | Internal oscillator clock; clocks all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_clk | input | 1 | External primary oscillator under watch |
| smp_clk | input | 1 | Slow internal sample clock |
| osc_mode | input | 3 | Oscillator mode code (0-2 crystal, others immediate) |
| sleep_enter | input | 1 | Pulse: device enters sleep |
| wake | input | 1 | Pulse: device wakes from sleep |
| sel_wr | input | 1 | Pulse: write of the software clock-select bit |
| sel_wr_data | input | 1 | Value written with `sel_wr` (1 = internal) |
| freq_wr | input | 1 | Pulse: write of the internal-oscillator frequency field |
| freq_data | input | FREQ_W | Value written with `freq_wr` |
| flag_clr | input | 1 | Pulse: request to clear the failure flag |
| sys_sel | output | 1 | Registered system clock select (1 = internal) |
| fs_active | output | 1 | Fail-safe state is active |
| fail_flag | output | 1 | Sticky failure flag |
| startup_done | output | 1 | Primary start-up and switchover have completed |
| int_freq | output | FREQ_W | Current internal-oscillator frequency field |

## Verification
The hardest situation to reach is a crystal start-up in which the primary is silent while the sample clock keeps running. The detector would declare a failure there if it were not gated, so the bench resets in a crystal mode with the primary held still and then drives full sample periods by hand. Fail-safe exit is also hard to reach, because it depends on the stored select bit. The bench first writes the same value, then the opposite value, and checks the flag-clear request both before and after the exit. Every mode code is swept, with the expected start-up timing derived from the primary period and the timer length.

// File: rtl/fscm_pkg.sv
package fscm_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [2:0] {
    ST_BOOT  = 3'd0,
    ST_START = 3'd1,
    ST_RUN   = 3'd2,
    ST_FAIL  = 3'd3,
    ST_SLEEP = 3'd4
  } fscm_state_e;

  // Crystal-type modes need a start-up wait before monitoring.
  function automatic logic mode_is_crystal(input logic [MODE_W-1:0] m);
    return (m <= MODE_W'(2));
  endfunction

endpackage

// File: rtl/fscm_edge_sync.sv
module fscm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);

  localparam int PW = STAGES + 1;

  logic [PW-1:0] pipe_q;
  logic [PW-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[PW-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rise = pipe_q[PW-2] & ~pipe_q[PW-1];
  assign fall = ~pipe_q[PW-2] & pipe_q[PW-1];

endmodule

// File: rtl/fscm_ost.sv
module fscm_ost #(
  parameter int OST_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  output logic done
);

  localparam int CW = $clog2(OST_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(OST_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!en)                      cnt_d = '0;
    else if (tick && cnt_q != LAST) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = en & tick & (cnt_q == LAST);

  AST_OST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);  // R2
  AST_OST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));  // R2

endmodule

// File: rtl/fscm_detect.sv
module fscm_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic smp_rise,
  input  logic smp_fall,
  input  logic pri_rise,
  output logic fail_det
);

  logic test_q;
  logic test_d;

  always_comb begin
    test_d = test_q;
    if (!en)           test_d = 1'b0;
    else if (smp_rise) test_d = 1'b1;
    else if (pri_rise) test_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) test_q <= 1'b0;
    else        test_q <= test_d;
  end

  assign fail_det = en & smp_fall & test_q & ~pri_rise;

  AST_LATCH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !test_q);  // R4
  AST_PRI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pri_rise && !smp_rise) |=> !test_q);  // R6

endmodule

// File: rtl/fscm_switchover.sv
module fscm_switchover
  import fscm_pkg::*;
#(
  parameter int OST_CYCLES  = 1024,
  parameter int SYNC_STAGES = 2,
  parameter int FREQ_W      = 3
) (
  input  logic              clk_int,
  input  logic              rst_n,
  input  logic              pri_clk,
  input  logic              smp_clk,
  input  logic [MODE_W-1:0] osc_mode,
  input  logic              sleep_enter,
  input  logic              wake,
  input  logic              sel_wr,
  input  logic              sel_wr_data,
  input  logic              freq_wr,
  input  logic [FREQ_W-1:0] freq_data,
  input  logic              flag_clr,
  output logic              sys_sel,
  output logic              fs_active,
  output logic              fail_flag,
  output logic              startup_done,
  output logic [FREQ_W-1:0] int_freq
);

  // Reset: asserted asynchronously, released synchronously.
  logic [1:0] rst_s_q;
  logic       rst_l_n;

  always_ff @(posedge clk_int or negedge rst_n) begin
    if (!rst_n) rst_s_q <= 2'b00;
    else        rst_s_q <= {rst_s_q[0], 1'b1};
  end
  assign rst_l_n = rst_s_q[1];

  // Edge detection of the slow clocks.
  logic pri_rise, pri_fall_unused;
  logic smp_rise, smp_fall;

  fscm_edge_sync #(.STAGES(SYNC_STAGES)) u_pri_sync (
    .clk(clk_int), .rst_n(rst_l_n), .din(pri_clk),
    .rise(pri_rise), .fall(pri_fall_unused)
  );

  fscm_edge_sync #(.STAGES(SYNC_STAGES)) u_smp_sync (
    .clk(clk_int), .rst_n(rst_l_n), .din(smp_clk),
    .rise(smp_rise), .fall(smp_fall)
  );

  fscm_state_e state_q, state_d;

  logic ost_done;
  logic fail_det;
  logic mon_en;
  logic ost_en;

  assign mon_en = (state_q == ST_RUN);
  assign ost_en = (state_q == ST_START);

  fscm_ost #(.OST_CYCLES(OST_CYCLES)) u_ost (
    .clk(clk_int), .rst_n(rst_l_n), .en(ost_en), .tick(pri_rise),
    .done(ost_done)
  );

  fscm_detect u_det (
    .clk(clk_int), .rst_n(rst_l_n), .en(mon_en),
    .smp_rise(smp_rise), .smp_fall(smp_fall), .pri_rise(pri_rise),
    .fail_det(fail_det)
  );

  logic              sw_sel_q, sw_sel_d;
  logic [FREQ_W-1:0] freq_q, freq_d;
  logic              flag_q, flag_d;
  logic              sel_q, sel_d;
  logic              fs_q, fs_d;
  logic              done_q, done_d;
  logic              sel_change;

  assign sel_change = sel_wr && (sel_wr_data != sw_sel_q);

  // Next-state logic.
  always_comb begin
    state_d = state_q;
    if (sleep_enter && state_q != ST_SLEEP) begin
      state_d = ST_SLEEP;
    end else begin
      unique case (state_q)
        ST_BOOT:  state_d = mode_is_crystal(osc_mode) ? ST_START : ST_RUN;
        ST_START: if (ost_done)   state_d = ST_RUN;
        ST_RUN:   if (fail_det)   state_d = ST_FAIL;
        ST_FAIL:  if (sel_change) state_d = ST_RUN;
        ST_SLEEP: if (wake)       state_d = ST_BOOT;
        default:  state_d = ST_BOOT;
      endcase
    end
  end

  always_comb begin
    sw_sel_d = sel_wr  ? sel_wr_data : sw_sel_q;
    freq_d   = freq_wr ? freq_data   : freq_q;

    flag_d = flag_q;
    if (state_q == ST_RUN && state_d == ST_FAIL) flag_d = 1'b1;
    else if (flag_clr && state_q != ST_FAIL)     flag_d = 1'b0;

    fs_d   = (state_d == ST_FAIL);
    done_d = (state_d == ST_RUN) || (state_d == ST_FAIL);
    sel_d  = (state_d == ST_RUN) ? sw_sel_d : 1'b1;
  end

  // Registers.
  always_ff @(posedge clk_int or negedge rst_l_n) begin
    if (!rst_l_n) begin
      state_q  <= ST_BOOT;
      sw_sel_q <= 1'b0;
      freq_q   <= '0;
      flag_q   <= 1'b0;
      fs_q     <= 1'b0;
      done_q   <= 1'b0;
      sel_q    <= 1'b1;
    end else begin
      state_q  <= state_d;
      sw_sel_q <= sw_sel_d;
      freq_q   <= freq_d;
      flag_q   <= flag_d;
      fs_q     <= fs_d;
      done_q   <= done_d;
      sel_q    <= sel_d;
    end
  end

  assign sys_sel      = sel_q;
  assign fs_active    = fs_q;
  assign fail_flag    = flag_q;
  assign startup_done = done_q;
  assign int_freq     = freq_q;

  AST_FS_INTERNAL: assert property (@(posedge clk_int) disable iff (!rst_l_n)
    fs_active |-> sys_sel);  // R7
  AST_FS_FLAG: assert property (@(posedge clk_int) disable iff (!rst_l_n)
    fs_active |-> fail_flag);  // R5
  AST_CLR_BLOCKED: assert property (@(posedge clk_int) disable iff (!rst_l_n)
    (fs_active && flag_clr) |=> fail_flag);  // R8
  AST_FS_EXIT: assert property (@(posedge clk_int) disable iff (!rst_l_n)
    $fell(fs_active) |-> ($past(sleep_enter) || $past(sel_wr)));  // R9
  AST_START_QUIET: assert property (@(posedge clk_int) disable iff (!rst_l_n)
    (state_q == ST_START) |-> !fail_det);  // R4
  AST_SLEEP_OUT: assert property (@(posedge clk_int) disable iff (!rst_l_n)
    (sleep_enter && state_q != ST_SLEEP) |=> (!startup_done && sys_sel && !fs_active));  // R11

endmodule

// File: tb/tb_fscm_switchover.sv
module tb_fscm_switchover;

  localparam int CLK_PERIOD = 10;
  localparam int OST        = 8;
  localparam int FREQ_W     = 3;
  localparam int PRI_CYC    = 6;   // primary period in clk_int cycles

  logic clk_int = 1'b0;
  logic rst_n = 1'b0;
  logic pri_clk = 1'b0;
  logic pri_run = 1'b1;
  logic smp_clk = 1'b0;
  logic [2:0] osc_mode = 3'd0;
  logic sleep_enter = 1'b0, wake = 1'b0;
  logic sel_wr = 1'b0, sel_wr_data = 1'b0;
  logic freq_wr = 1'b0;
  logic [FREQ_W-1:0] freq_data = '0;
  logic flag_clr = 1'b0;
  logic sys_sel, fs_active, fail_flag, startup_done;
  logic [FREQ_W-1:0] int_freq;

  int checks = 0;
  int errors = 0;

  fscm_switchover #(.OST_CYCLES(OST), .SYNC_STAGES(2), .FREQ_W(FREQ_W)) dut (
    .clk_int(clk_int), .rst_n(rst_n), .pri_clk(pri_clk), .smp_clk(smp_clk),
    .osc_mode(osc_mode), .sleep_enter(sleep_enter), .wake(wake),
    .sel_wr(sel_wr), .sel_wr_data(sel_wr_data), .freq_wr(freq_wr),
    .freq_data(freq_data), .flag_clr(flag_clr), .sys_sel(sys_sel),
    .fs_active(fs_active), .fail_flag(fail_flag),
    .startup_done(startup_done), .int_freq(int_freq)
  );

  always #(CLK_PERIOD/2) clk_int = ~clk_int;

  // Primary toggles on clk_int falling edges while enabled.
  initial forever begin
    #(PRI_CYC*CLK_PERIOD/2);
    if (pri_run) pri_clk = ~pri_clk;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_int);
  endtask

  task automatic do_reset(input logic [2:0] m);
    @(negedge clk_int);
    rst_n = 1'b0;
    osc_mode = m;
    cyc(3);
    rst_n = 1'b1;
    cyc(5);
  endtask

  task automatic sample_period();
    smp_clk = 1'b1;
    cyc(20);
    smp_clk = 1'b0;
    cyc(20);
  endtask

  task automatic pulse_sel(input logic v);
    sel_wr = 1'b1; sel_wr_data = v;
    cyc(1);
    sel_wr = 1'b0;
    cyc(2);
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1;
    cyc(1);
    flag_clr = 1'b0;
    cyc(2);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD*150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int m = 0; m < 8; m++) begin
      bit xtal;
      xtal = (m <= 2);
      pri_run = 1'b1;
      do_reset(3'(m));
      chk("R1/R3 fs after reset", fs_active, 0);
      chk("R1/R3 flag after reset", fail_flag, 0);
      if (xtal) begin
        chk("R1 done in start-up", startup_done, 0);
        chk("R1 sel in start-up", sys_sel, 1);
        cyc((OST-2)*PRI_CYC - 8);
        chk("R2 done before timer", startup_done, 0);
        cyc(4*PRI_CYC + 8);
        chk("R2 done after timer", startup_done, 1);
        chk("R2 sel after timer", sys_sel, 0);
      end else begin
        chk("R3 done immediately", startup_done, 1);
        chk("R3 sel immediately", sys_sel, 0);
      end
      // R6: running primary, no failure.
      sample_period();
      sample_period();
      chk("R6 no false failure", fs_active, 0);
      // R12: select write in run.
      pulse_sel(1'b1);
      chk("R12 sel follows bit 1", sys_sel, 1);
      pulse_sel(1'b0);
      chk("R12 sel follows bit 0", sys_sel, 0);
      // R5: stop primary.
      pri_run = 1'b0;
      cyc(12);
      sample_period();
      chk("R5 fs set", fs_active, 1);
      chk("R5 flag set", fail_flag, 1);
      chk("R7 sel internal", sys_sel, 1);
      pulse_clr();
      chk("R8 clear ignored in fail-safe", fail_flag, 1);
      freq_data = 3'(m + 1); freq_wr = 1'b1;
      cyc(1);
      freq_wr = 1'b0;
      cyc(2);
      chk("R10 freq loaded", int_freq, (m + 1) % 8);
      chk("R10 fs kept", fs_active, 1);
      pulse_sel(1'b0);
      chk("R9 same-value write keeps fs", fs_active, 1);
      chk("R7 sel internal with bit 0", sys_sel, 1);
      pulse_sel(1'b1);
      chk("R9 changing write exits fs", fs_active, 0);
      chk("R9 flag survives exit", fail_flag, 1);
      chk("R12 sel after exit", sys_sel, 1);
      pulse_clr();
      chk("R8 clear accepted after exit", fail_flag, 0);
    end

    // R4: crystal start-up with silent primary.
    pri_run = 1'b0;
    do_reset(3'd1);
    sample_period();
    sample_period();
    chk("R4 no fs during start-up", fs_active, 0);
    chk("R4 no flag during start-up", fail_flag, 0);
    chk("R4 still starting", startup_done, 0);

    // R9 reset exit and R11 sleep.
    pri_run = 1'b1;
    do_reset(3'd3);
    pri_run = 1'b0;
    cyc(12);
    sample_period();
    chk("R5 fs set (EC)", fs_active, 1);
    sleep_enter = 1'b1;
    cyc(1);
    sleep_enter = 1'b0;
    cyc(2);
    chk("R11 fs cleared by sleep", fs_active, 0);
    chk("R11 done low in sleep", startup_done, 0);
    chk("R11 sel internal in sleep", sys_sel, 1);
    chk("R11 flag kept in sleep", fail_flag, 1);
    osc_mode = 3'd2;
    pri_run = 1'b1;
    wake = 1'b1;
    cyc(1);
    wake = 1'b0;
    cyc(3);
    chk("R11/R1 start-up after wake", startup_done, 0);
    cyc((OST+2)*PRI_CYC + 8);
    chk("R11/R2 done after wake", startup_done, 1);
    pri_run = 1'b0;
    cyc(12);
    sample_period();
    chk("R5 fs set after wake", fs_active, 1);
    do_reset(3'd4);
    chk("R9 reset clears fs", fs_active, 0);
    chk("R9 reset clears flag", fail_flag, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule